// File: doc/BRIEF.md
# Planar Tile Row Decoder

This block turns one eight-pixel row of an 8x8 planar tile into eight color indices. A tile stores its pixels as separate bit planes. The planes are grouped in pairs: for a given row, the byte of the even plane sits directly next to the byte of the odd plane. Consecutive rows of a pair are two bytes apart, and each further pair begins sixteen bytes after the one before it. A tile can hold 2, 4 or 8 planes, which gives 2, 4 or 8 bits per pixel.

A caller pulses `start` together with a row number, horizontal and vertical flip flags and a depth code. The block works out the byte offset of each plane byte within the tile. It issues these offsets one at a time on a request/valid memory port, waits for each byte to come back, and collects one bit per plane for every pixel. Once the last byte has arrived, it presents all eight indices at once and raises `done` for one cycle. Vertical flip reads the mirrored row. Horizontal flip reverses the order of the pixels. Palette lookup is left to the next stage.

Top module: `bitplane_row_unpacker`

## Requirements
- R1: During reset and right after it, `busy`, `req_valid` and `done` are low and `pix_idx` is all zeros.
- R2: Depth code 0 selects 2 planes, code 1 selects 4 planes, and codes 2 and 3 both select 8 planes. One `start` produces exactly that many fetches.
- R3: Fetch n (numbered from 0) requests offset 16*(n/2) + 2*r + (n mod 2), where r is the effective row. Offsets therefore go out in ascending order.
- R4: When vertical flip is clear, the effective row is the row input. When it is set, the effective row is 7 minus the row input.
- R5: Bit b of each index comes from the byte fetched for plane b (fetch b). With no horizontal flip, output pixel p sits at `pix_idx[8p+7:8p]` and takes bit 7-p of each plane byte, so bit 7 is the leftmost pixel.
- R6: When horizontal flip is set, output pixel p takes bit p of each plane byte, which reverses the order of the pixels.
- R7: At 2 and 4 bits per pixel, index bits 2 and above, or 4 and above, are zero.
- R8: `done` is high for exactly one cycle. It rises two cycles after the cycle in which the last `rd_valid` is high. `pix_idx` changes only in the cycle in which `done` is high, and holds its value otherwise.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the fetch sequence or on the result.
- R10: `req_valid` is high for a single cycle per fetch. No new request goes out until `rd_valid` has returned the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding a row (accepted only while idle) |
| row | input | 3 | Tile row number, 0 = top |
| hflip | input | 1 | Mirror the pixels horizontally |
| vflip | input | 1 | Mirror the tile vertically |
| depth | input | 2 | Bits-per-pixel code (0:2, 1:4, 2/3:8) |
| busy | output | 1 | Decode in progress |
| req_valid | output | 1 | Fetch request strobe |
| req_offset | output | 6 | Byte offset within the tile to fetch |
| rd_valid | input | 1 | Fetched byte is present on rd_data |
| rd_data | input | 8 | Fetched plane byte |
| done | output | 1 | One-cycle result strobe |
| pix_idx | output | 64 | Eight 8-bit indices, pixel 0 (leftmost) in bits 7:0 |

## Verification
The bench builds the block with its default geometry: eight rows, eight pixels per row and up to eight planes. With those values the full 6-bit offset range is exercised, including the top pair of the 8-bit-per-pixel layout, and the reserved depth code 3 is included. The memory model in the bench is run with response latencies of one and of several cycles, which checks that requests wait for the returned byte. Different data seeds per scenario make sure that each plane lands in its own index bit.

// File: rtl/bprow_pkg.sv
package bprow_pkg;
  localparam int TILE_ROWS   = 8;
  localparam int ROW_PIX     = 8;
  localparam int MAX_PLANES  = 8;
  localparam int PAIR_STRIDE = 2 * TILE_ROWS;
  localparam int ROW_W       = $clog2(TILE_ROWS);
  localparam int OFF_W       = $clog2((MAX_PLANES / 2) * PAIR_STRIDE);
  localparam int CNT_W       = $clog2(MAX_PLANES);
  localparam int IDX_W       = MAX_PLANES;
  localparam int PIX_VEC_W   = ROW_PIX * IDX_W;
  localparam int PLANE_VEC_W = MAX_PLANES * ROW_PIX;

  typedef enum logic [1:0] {
    DEP_2BPP     = 2'd0,
    DEP_4BPP     = 2'd1,
    DEP_8BPP     = 2'd2,
    DEP_8BPP_ALT = 2'd3
  } depth_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } ctl_state_e;

  function automatic logic [CNT_W:0] planes_of(input logic [1:0] code);
    case (code)
      DEP_2BPP: planes_of = (CNT_W+1)'(2);
      DEP_4BPP: planes_of = (CNT_W+1)'(4);
      default:  planes_of = (CNT_W+1)'(MAX_PLANES);
    endcase
  endfunction
endpackage

// File: rtl/bprow_offset_gen.sv
module bprow_offset_gen
  import bprow_pkg::*;
(
  input  logic [CNT_W-1:0] fetch_idx,
  input  logic [ROW_W-1:0] row,
  input  logic             vflip,
  output logic [OFF_W-1:0] offset
);
  logic [ROW_W-1:0] eff_row;

  always_comb begin
    eff_row = vflip ? (ROW_W'(TILE_ROWS - 1) - row) : row;
    offset  = OFF_W'(fetch_idx >> 1) * OFF_W'(PAIR_STRIDE)
            + OFF_W'({eff_row, 1'b0})
            + OFF_W'(fetch_idx[0]);
  end
endmodule

// File: rtl/bprow_plane_store.sv
module bprow_plane_store
  import bprow_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [CNT_W-1:0]       wsel,
  input  logic [ROW_PIX-1:0]     wdata,
  output logic [PLANE_VEC_W-1:0] planes
);
  for (genvar g = 0; g < MAX_PLANES; g++) begin : g_plane
    logic [ROW_PIX-1:0] plane_q;
    logic [ROW_PIX-1:0] plane_d;
    logic               plane_en;

    always_comb begin
      plane_en = clr || (we && (wsel == CNT_W'(g)));
      plane_d  = clr ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        plane_q <= '0;
      else if (plane_en) plane_q <= plane_d;
    end

    assign planes[g*ROW_PIX +: ROW_PIX] = plane_q;
  end
endmodule

// File: rtl/bprow_pixel_form.sv
module bprow_pixel_form
  import bprow_pkg::*;
(
  input  logic [PLANE_VEC_W-1:0] planes,
  input  logic                   hflip,
  input  logic [CNT_W:0]         nplanes,
  output logic [PIX_VEC_W-1:0]   pix
);
  always_comb begin
    pix = '0;
    for (int p = 0; p < ROW_PIX; p++) begin
      for (int b = 0; b < IDX_W; b++) begin
        if (b < int'(nplanes)) begin
          pix[p*IDX_W + b] = hflip ? planes[b*ROW_PIX + p]
                                   : planes[b*ROW_PIX + (ROW_PIX - 1 - p)];
        end
      end
    end
  end
endmodule

// File: rtl/bitplane_row_unpacker.sv
module bitplane_row_unpacker
  import bprow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ROW_W-1:0]     row,
  input  logic                 hflip,
  input  logic                 vflip,
  input  logic [1:0]           depth,
  output logic                 busy,
  output logic                 req_valid,
  output logic [OFF_W-1:0]     req_offset,
  input  logic                 rd_valid,
  input  logic [ROW_PIX-1:0]   rd_data,
  output logic                 done,
  output logic [PIX_VEC_W-1:0] pix_idx
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctl_state_e           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [ROW_W-1:0]     row_q;
  logic                 hflip_q, vflip_q;
  logic [CNT_W:0]       nplanes_q;
  logic                 cfg_ld, clr, we, out_en;
  logic                 done_q, done_d;
  logic [PIX_VEC_W-1:0] pix_q, pix_form;
  logic [PLANE_VEC_W-1:0] planes;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_ld  = 1'b0;
    clr     = 1'b0;
    we      = 1'b0;
    out_en  = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        cfg_ld  = 1'b1;
        clr     = 1'b1;
        cnt_d   = '0;
        state_d = ST_REQ;
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: if (rd_valid) begin
        we = 1'b1;
        if ({1'b0, cnt_q} == nplanes_q - 1'b1) begin
          state_d = ST_FIN;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_FIN: begin
        out_en  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      row_q     <= '0;
      hflip_q   <= 1'b0;
      vflip_q   <= 1'b0;
      nplanes_q <= (CNT_W+1)'(2);
    end else if (cfg_ld) begin
      row_q     <= row;
      hflip_q   <= hflip;
      vflip_q   <= vflip;
      nplanes_q <= planes_of(depth);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  pix_q <= '0;
    else if (out_en) pix_q <= pix_form;
  end

  bprow_offset_gen u_offset (
    .fetch_idx (cnt_q),
    .row       (row_q),
    .vflip     (vflip_q),
    .offset    (req_offset)
  );

  bprow_plane_store u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr),
    .we     (we),
    .wsel   (cnt_q),
    .wdata  (rd_data),
    .planes (planes)
  );

  bprow_pixel_form u_form (
    .planes  (planes),
    .hflip   (hflip_q),
    .nplanes (nplanes_q),
    .pix     (pix_form)
  );

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign done      = done_q;
  assign pix_idx   = pix_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R10
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(pix_idx))); // R8
  AST_OFFSET_IN_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_offset) < int'(nplanes_q) * (PAIR_STRIDE / 2))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R1
endmodule

// File: tb/sim_bitplane_row_unpacker.sv
`timescale 1ns/1ps
module sim_bitplane_row_unpacker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  row;
  logic        hflip, vflip;
  logic [1:0]  depth;
  logic        busy, req_valid, rd_valid, done;
  logic [5:0]  req_offset;
  logic [7:0]  rd_data;
  logic [63:0] pix_idx;

  always #2.5 clk = ~clk;

  bitplane_row_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .row(row), .hflip(hflip),
    .vflip(vflip), .depth(depth), .busy(busy), .req_valid(req_valid),
    .req_offset(req_offset), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .pix_idx(pix_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // memory model
  logic [7:0] seed = 8'h00;
  int lat = 1;
  int wcnt = 0;
  logic [5:0] poff;
  int nfetch = 0;
  int proto_err = 0;
  int last_rd_cyc = 0;
  logic [5:0] flog [0:15];

  function automatic logic [7:0] mem_byte(input logic [5:0] off, input logic [7:0] sd);
    logic [7:0] o8;
    o8 = {2'b00, off};
    return (o8 * 8'd37) ^ (sd * 8'd91) ^ 8'hA5;
  endfunction

  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (req_valid) begin
      if (wcnt > 0) proto_err++;
      if (nfetch < 16) flog[nfetch] = req_offset;
      nfetch++;
      poff = req_offset;
      wcnt = lat;
    end else if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) begin
        rd_valid = 1'b1;
        rd_data  = mem_byte(poff, seed);
        last_rd_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; row = '0; hflip = 0; vflip = 0; depth = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !done, "R1", "strobes in reset",
        {busy, req_valid, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !req_valid && !done, "R1", "strobes after reset",
        {busy, req_valid, done}, 0);
    chk(pix_idx == 0, "R1", "pix after reset", pix_idx, 0);
  endtask

  task automatic run_case(input logic [1:0] d, input logic [2:0] r, input bit hf,
                          input bit vf, input logic [7:0] sd, input int lt,
                          input bit restart, input string tag);
    int nf, er, k, bp, cnt_err;
    logic [63:0] pexp, held;
    logic [7:0] e;
    seed = sd; lat = lt; nfetch = 0; proto_err = 0;
    nf = (d == 2'd0) ? 2 : (d == 2'd1) ? 4 : 8;
    er = vf ? 7 - int'(r) : int'(r);
    @(negedge clk);
    start = 1'b1; depth = d; row = r; hflip = hf; vflip = vf;
    @(negedge clk);
    start = 1'b0; depth = ~d; row = ~r; hflip = ~hf; vflip = ~vf;
    k = 0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
      start = (restart && (k == 3 || k == 6)) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    chk(done, "R8", {tag, " done seen"}, done, 1);
    chk(cyc - last_rd_cyc == 2, "R8", {tag, " done latency"}, cyc - last_rd_cyc, 2);
    chk(nfetch == nf, restart ? "R9" : "R2", {tag, " fetch count"}, nfetch, nf);
    chk(proto_err == 0, "R10", {tag, " request overlap"}, proto_err, 0);
    cnt_err = 0;
    for (int n = 0; n < nf && n < 16; n++) begin
      if (flog[n] != 6'(16 * (n / 2) + 2 * er + (n % 2))) cnt_err++;
    end
    chk(cnt_err == 0, vf ? "R4" : "R3", {tag, " offsets"}, cnt_err, 0);
    pexp = '0;
    for (int p = 0; p < 8; p++) begin
      bp = hf ? p : 7 - p;
      for (int b = 0; b < nf; b++) begin
        e = mem_byte(6'(16 * (b / 2) + 2 * er + (b % 2)), sd);
        pexp[p*8 + b] = e[bp];
      end
    end
    for (int p = 0; p < 8; p++) begin
      chk(pix_idx[p*8 +: 8] == pexp[p*8 +: 8], hf ? "R6" : "R5",
          $sformatf("%s pixel %0d", tag, p), pix_idx[p*8 +: 8], pexp[p*8 +: 8]);
    end
    if (nf < 8) begin
      cnt_err = 0;
      for (int p = 0; p < 8; p++) if ((pix_idx[p*8 +: 8] >> nf) != 0) cnt_err++;
      chk(cnt_err == 0, "R7", {tag, " upper bits"}, cnt_err, 0);
    end
    held = pix_idx;
    repeat (3) @(negedge clk);
    chk(!done, "R8", {tag, " done width"}, done, 0);
    chk(pix_idx == held, "R8", {tag, " pix held"}, pix_idx, held);
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    run_case(2'd0, 3'd0, 0, 0, 8'h11, 1, 0, "2bpp row0");
    run_case(2'd1, 3'd5, 0, 0, 8'h22, 3, 0, "4bpp row5");
    run_case(2'd2, 3'd7, 0, 0, 8'h33, 1, 0, "8bpp row7");
    run_case(2'd3, 3'd2, 0, 0, 8'h44, 2, 0, "code3 row2");
    run_case(2'd1, 3'd1, 0, 1, 8'h55, 1, 0, "vflip");
    run_case(2'd2, 3'd3, 1, 0, 8'h66, 1, 0, "hflip");
    run_case(2'd0, 3'd6, 1, 1, 8'h77, 4, 0, "both flips");
    run_case(2'd2, 3'd4, 0, 0, 8'h88, 2, 1, "restart ignored");
    run_case(2'd0, 3'd3, 0, 0, 8'h99, 1, 0, "shrink after 8bpp");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule